// File: doc/BRIEF.md
# Second-Operand Immediate Generator

This block produces the second source operand of a 32-bit fixed-length instruction for an instruction decoder. A first-level decoder supplies a 4-bit source select code alongside the raw instruction word. From these the block forms one of three results. The first is a general-register read request with its 5-bit index. The second is a special-register read request for either the count register or the link register. The third is a 64-bit immediate constant built in one of ten formats. Each format has its own field, shift and extension rule. At most one of the three valid flags is raised for a given instruction.

In the same cycle the block also resolves three single-bit control fields. The record flag is forced to 0, forced to 1, or taken from the instruction, under a 2-bit select. The overflow-enable flag is always taken from the instruction. The link flag comes from the instruction when the operation carries the link attribute.

All results are registered. They appear one clock after the inputs are presented, and they clear on a synchronous active-high reset.

Instruction bits below are numbered LSB-first, `insn_i[0]` being the last bit of the word.

Top module: `opgen_top`

## Requirements
- R1: While `rst` is high at a rising edge, every output becomes 0 after that edge, including `rec_ok_o` and `ovf_ok_o`.
- R2: Every output reflects the inputs sampled at the previous rising edge. A change of input is not visible before the next rising edge.
- R3: Select 1 (register B) gives `rd2_ok_o`=1 and `rd2_idx_o`=`insn_i[15:11]`, with `imm_ok_o`=0, `spr2_ok_o`=0 and `imm_o`=0.
- R4: Select 0 (no operand) and the undefined selects 13, 14 and 15 give all three valid flags 0. In that case `imm_o`, `rd2_idx_o` and `spr2_num_o` are 0.
- R5: Select 2 (special register) gives `spr2_ok_o`=1, with `imm_ok_o`=0 and `rd2_ok_o`=0. `spr2_num_o` is 9 (count register) when `insn_i[10]`=1, and 8 (link register) when it is 0.
- R6: Select 3 gives `insn_i[15:0]` zero-extended to 64 bits. Select 4 gives the same field sign-extended from bit 15.
- R7: Select 5 gives `insn_i[15:0]` shifted left by 16 and zero-extended. Select 6 gives the same 32-bit value sign-extended from bit 31.
- R8: Select 7 gives `insn_i[25:2]` shifted left by 2. Selects 8 and 9 give `insn_i[15:2]` shifted left by 2. All three results are zero-extended.
- R9: Select 10 gives all ones. Select 12 gives `insn_i[15:11]`. Select 11 gives a 6-bit value whose low five bits are `insn_i[15:11]` and whose bit 5 is `insn_i[1]`. Both shift amounts are zero-extended.
- R10: For every immediate select (3 to 12) `imm_ok_o`=1, `rd2_ok_o`=0 and `spr2_ok_o`=0. No two of the three valid flags are ever 1 together.
- R11: Out of reset `rec_ok_o`=1. `rec_o` is 0 for record select 0, 1 for record select 1, `insn_i[0]` for record select 2, and 0 for record select 3.
- R12: Out of reset `ovf_ok_o`=1 and `ovf_o`=`insn_i[10]`.
- R13: `link_o` equals `insn_i[0]` when `link_en_i`=1, and is 0 when `link_en_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| insn_i | input | 32 | Raw instruction word |
| sel2_i | input | 4 | Second-operand source select code |
| rec_sel_i | input | 2 | Record-flag source select |
| link_en_i | input | 1 | Operation carries the link attribute |
| imm_o | output | 64 | Immediate constant |
| imm_ok_o | output | 1 | Immediate is valid |
| rd2_idx_o | output | 5 | General-register read index |
| rd2_ok_o | output | 1 | General-register read requested |
| spr2_num_o | output | 10 | Special-register number |
| spr2_ok_o | output | 1 | Special-register read requested |
| rec_o | output | 1 | Record flag value |
| rec_ok_o | output | 1 | Record flag valid |
| ovf_o | output | 1 | Overflow-enable value |
| ovf_ok_o | output | 1 | Overflow-enable valid |
| link_o | output | 1 | Link flag |

## Verification
Every result of this block, including the valid flags and the three control bits, is due exactly one rising edge after the inputs are presented. The bench drives each stimulus on a falling edge and compares the outputs on the following falling edge, half a period after the edge that loads them. For the latency requirement it also samples one nanosecond after a fresh drive, before any rising edge. At that point the previous result must still be present. The reset check samples on the falling edge after a reset edge, when the cleared register contents are due.

// File: rtl/opgen_pkg.sv
package opgen_pkg;

  typedef enum logic [3:0] {
    SRC_NONE  = 4'd0,
    SRC_RB    = 4'd1,
    SRC_SPR   = 4'd2,
    SRC_U16   = 4'd3,
    SRC_S16   = 4'd4,
    SRC_U16HI = 4'd5,
    SRC_S16HI = 4'd6,
    SRC_LONG  = 4'd7,
    SRC_BR14  = 4'd8,
    SRC_DW14  = 4'd9,
    SRC_ONES  = 4'd10,
    SRC_SH6   = 4'd11,
    SRC_SH5   = 4'd12,
    SRC_U13   = 4'd13,
    SRC_U14   = 4'd14,
    SRC_U15   = 4'd15
  } src2_e;

  typedef enum logic [1:0] {
    REC_ZERO = 2'd0,
    REC_ONE  = 2'd1,
    REC_BIT  = 2'd2,
    REC_RSVD = 2'd3
  } rec_e;

endpackage

// File: rtl/opgen_fields.sv
module opgen_fields (
  input  logic [31:0] insn,
  output logic [4:0]  rb5,
  output logic [15:0] d16,
  output logic [23:0] li24,
  output logic [13:0] d14,
  output logic [5:0]  sh6,
  output logic        xo_top,
  output logic        rc_bit,
  output logic        oe_bit,
  output logic        lk_bit
);
  // Primary opcode is decoded upstream; it is not needed here.
  logic unused_opc;
  assign unused_opc = ^insn[31:26];

  assign rb5    = insn[15:11];
  assign d16    = insn[15:0];
  assign li24   = insn[25:2];
  assign d14    = insn[15:2];
  assign sh6    = {insn[1], insn[15:11]};
  assign xo_top = insn[10];
  assign rc_bit = insn[0];
  assign oe_bit = insn[10];
  assign lk_bit = insn[0];
endmodule

// File: rtl/opgen_imm.sv
module opgen_imm
  import opgen_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  src2_e             sel,
  input  logic [15:0]       d16,
  input  logic [23:0]       li24,
  input  logic [13:0]       d14,
  input  logic [5:0]        sh6,
  output logic [XLEN-1:0]   imm,
  output logic              imm_en
);
  localparam int PAD16 = XLEN - 16;
  localparam int PAD32 = XLEN - 32;
  localparam int PADLI = XLEN - 26;
  localparam int PADSH = XLEN - 6;
  localparam int PAD5  = XLEN - 5;

  always_comb begin
    imm    = '0;
    imm_en = 1'b1;
    unique case (sel)
      SRC_U16:   imm = {{PAD16{1'b0}}, d16};
      SRC_S16:   imm = {{PAD16{d16[15]}}, d16};
      SRC_U16HI: imm = {{PAD32{1'b0}}, d16, 16'h0000};
      SRC_S16HI: imm = {{PAD32{d16[15]}}, d16, 16'h0000};
      SRC_LONG:  imm = {{PADLI{1'b0}}, li24, 2'b00};
      SRC_BR14,
      SRC_DW14:  imm = {{PAD16{1'b0}}, d14, 2'b00};
      SRC_ONES:  imm = '1;
      SRC_SH6:   imm = {{PADSH{1'b0}}, sh6};
      SRC_SH5:   imm = {{PAD5{1'b0}}, sh6[4:0]};
      default:   imm_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/opgen_route.sv
module opgen_route
  import opgen_pkg::*;
#(
  parameter int SPRW    = 10,
  parameter int SPR_CNT = 9,
  parameter int SPR_LNK = 8
) (
  input  src2_e            sel,
  input  rec_e             rsel,
  input  logic             link_en,
  input  logic [4:0]       rb5,
  input  logic             xo_top,
  input  logic             rc_bit,
  input  logic             oe_bit,
  input  logic             lk_bit,
  output logic [4:0]       rd2_idx,
  output logic             rd2_en,
  output logic [SPRW-1:0]  spr2_num,
  output logic             spr2_en,
  output logic             rec_val,
  output logic             ovf_val,
  output logic             link_val
);
  localparam logic [SPRW-1:0] CNT_ID = SPRW'(SPR_CNT);
  localparam logic [SPRW-1:0] LNK_ID = SPRW'(SPR_LNK);

  always_comb begin
    rd2_idx  = '0;
    rd2_en   = 1'b0;
    spr2_num = '0;
    spr2_en  = 1'b0;
    if (sel == SRC_RB) begin
      rd2_idx = rb5;
      rd2_en  = 1'b1;
    end
    if (sel == SRC_SPR) begin
      spr2_num = xo_top ? CNT_ID : LNK_ID;
      spr2_en  = 1'b1;
    end
  end

  always_comb begin
    unique case (rsel)
      REC_ONE: rec_val = 1'b1;
      REC_BIT: rec_val = rc_bit;
      default: rec_val = 1'b0;
    endcase
  end

  assign ovf_val  = oe_bit;
  assign link_val = link_en & lk_bit;
endmodule

// File: rtl/opgen_top.sv
module opgen_top
  import opgen_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int SPRW    = 10,
  parameter int SPR_CNT = 9,
  parameter int SPR_LNK = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       insn_i,
  input  logic [3:0]        sel2_i,
  input  logic [1:0]        rec_sel_i,
  input  logic              link_en_i,
  output logic [XLEN-1:0]   imm_o,
  output logic              imm_ok_o,
  output logic [4:0]        rd2_idx_o,
  output logic              rd2_ok_o,
  output logic [SPRW-1:0]   spr2_num_o,
  output logic              spr2_ok_o,
  output logic              rec_o,
  output logic              rec_ok_o,
  output logic              ovf_o,
  output logic              ovf_ok_o,
  output logic              link_o
);
  localparam logic [SPRW-1:0] CNT_ID = SPRW'(SPR_CNT);
  localparam logic [SPRW-1:0] LNK_ID = SPRW'(SPR_LNK);

  src2_e sel;
  rec_e  rsel;
  assign sel  = src2_e'(sel2_i);
  assign rsel = rec_e'(rec_sel_i);

  logic [4:0]  f_rb5;
  logic [15:0] f_d16;
  logic [23:0] f_li24;
  logic [13:0] f_d14;
  logic [5:0]  f_sh6;
  logic        f_xo, f_rc, f_oe, f_lk;

  opgen_fields u_fields (
    .insn(insn_i), .rb5(f_rb5), .d16(f_d16), .li24(f_li24), .d14(f_d14),
    .sh6(f_sh6), .xo_top(f_xo), .rc_bit(f_rc), .oe_bit(f_oe), .lk_bit(f_lk)
  );

  logic [XLEN-1:0] imm_c;
  logic            imm_en_c;

  opgen_imm #(.XLEN(XLEN)) u_imm (
    .sel(sel), .d16(f_d16), .li24(f_li24), .d14(f_d14), .sh6(f_sh6),
    .imm(imm_c), .imm_en(imm_en_c)
  );

  logic [4:0]      rd2_idx_c;
  logic            rd2_en_c;
  logic [SPRW-1:0] spr2_num_c;
  logic            spr2_en_c;
  logic            rec_c, ovf_c, link_c;

  opgen_route #(.SPRW(SPRW), .SPR_CNT(SPR_CNT), .SPR_LNK(SPR_LNK)) u_route (
    .sel(sel), .rsel(rsel), .link_en(link_en_i), .rb5(f_rb5), .xo_top(f_xo),
    .rc_bit(f_rc), .oe_bit(f_oe), .lk_bit(f_lk),
    .rd2_idx(rd2_idx_c), .rd2_en(rd2_en_c), .spr2_num(spr2_num_c),
    .spr2_en(spr2_en_c), .rec_val(rec_c), .ovf_val(ovf_c), .link_val(link_c)
  );

  logic flags_ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      imm_o      <= '0;
      imm_ok_o   <= 1'b0;
      rd2_idx_o  <= '0;
      rd2_ok_o   <= 1'b0;
      spr2_num_o <= '0;
      spr2_ok_o  <= 1'b0;
      rec_o      <= 1'b0;
      ovf_o      <= 1'b0;
      link_o     <= 1'b0;
      flags_ok_q <= 1'b0;
    end else begin
      imm_o      <= imm_c;
      imm_ok_o   <= imm_en_c;
      rd2_idx_o  <= rd2_idx_c;
      rd2_ok_o   <= rd2_en_c;
      spr2_num_o <= spr2_num_c;
      spr2_ok_o  <= spr2_en_c;
      rec_o      <= rec_c;
      ovf_o      <= ovf_c;
      link_o     <= link_c;
      flags_ok_q <= 1'b1;
    end
  end

  assign rec_ok_o = flags_ok_q;
  assign ovf_ok_o = flags_ok_q;

  // rec_ok_o high means the previous edge loaded from the inputs.
  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!imm_ok_o && !rd2_ok_o && !spr2_ok_o && !rec_ok_o && imm_o == '0));

  assert_rb_R3: assert property (@(posedge clk) disable iff (rst)
    (rec_ok_o && $past(sel2_i) == 4'd1) |->
      (rd2_ok_o && rd2_idx_o == $past(insn_i[15:11]) && !imm_ok_o));

  assert_none_R4: assert property (@(posedge clk) disable iff (rst)
    (rec_ok_o && ($past(sel2_i) == 4'd0 || $past(sel2_i) >= 4'd13)) |->
      (!imm_ok_o && !rd2_ok_o && !spr2_ok_o));

  assert_spr_R5: assert property (@(posedge clk) disable iff (rst)
    (rec_ok_o && $past(sel2_i) == 4'd2) |->
      (spr2_ok_o && spr2_num_o == ($past(insn_i[10]) ? CNT_ID : LNK_ID)));

  assert_ones_R9: assert property (@(posedge clk) disable iff (rst)
    (rec_ok_o && $past(sel2_i) == 4'd10) |-> (imm_ok_o && imm_o == '1));

  assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({imm_ok_o, rd2_ok_o, spr2_ok_o}));

  assert_ovf_R12: assert property (@(posedge clk) disable iff (rst)
    rec_ok_o |-> (ovf_ok_o && ovf_o == $past(insn_i[10])));

  assert_link_R13: assert property (@(posedge clk) disable iff (rst)
    (rec_ok_o && !$past(link_en_i)) |-> !link_o);
endmodule

// File: tb/test_opgen_top.sv
`timescale 1ns/1ps
module test_opgen_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic [31:0] insn;
  logic [3:0]  sel2;
  logic [1:0]  rsel;
  logic        lken;
  logic [63:0] imm_o;
  logic        imm_ok_o, rd2_ok_o, spr2_ok_o, rec_o, rec_ok_o, ovf_o, ovf_ok_o, link_o;
  logic [4:0]  rd2_idx_o;
  logic [9:0]  spr2_num_o;

  opgen_top i_opgen_top (
    .clk(clk), .rst(rst), .insn_i(insn), .sel2_i(sel2), .rec_sel_i(rsel),
    .link_en_i(lken), .imm_o(imm_o), .imm_ok_o(imm_ok_o), .rd2_idx_o(rd2_idx_o),
    .rd2_ok_o(rd2_ok_o), .spr2_num_o(spr2_num_o), .spr2_ok_o(spr2_ok_o),
    .rec_o(rec_o), .rec_ok_o(rec_ok_o), .ovf_o(ovf_o), .ovf_ok_o(ovf_ok_o),
    .link_o(link_o)
  );

  int total = 0;
  int bad   = 0;

  logic [63:0] e_imm;
  logic [2:0]  e_oks;
  logic [4:0]  e_rd2;
  logic [9:0]  e_spr;
  logic        e_rec, e_ovf, e_lnk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_for(input int s);
    case (s)
      1: return "R3";
      2: return "R5";
      3, 4: return "R6";
      5, 6: return "R7";
      7, 8, 9: return "R8";
      10, 11, 12: return "R9";
      default: return "R4";
    endcase
  endfunction

  task automatic predict(input logic [31:0] w, input int s, input int rs, input logic lk);
    longint sv;
    e_imm = 64'd0; e_oks = 3'b000; e_rd2 = 5'd0; e_spr = 10'd0;
    case (s)
      1: begin e_oks = 3'b010; e_rd2 = 5'((w >> 11) & 32'd31); end
      2: begin e_oks = 3'b001; e_spr = ((w >> 10) & 32'd1) != 0 ? 10'd9 : 10'd8; end
      3: e_imm = 64'(w & 32'h0000_FFFF);
      4: begin sv = longint'(shortint'(w[15:0])); e_imm = 64'(sv); end
      5: e_imm = 64'(w & 32'h0000_FFFF) << 16;
      6: begin sv = longint'(int'({w[15:0], 16'h0000})); e_imm = 64'(sv); end
      7: e_imm = 64'(w & 32'h03FF_FFFC);
      8, 9: e_imm = 64'(w & 32'h0000_FFFC);
      10: e_imm = 64'hFFFF_FFFF_FFFF_FFFF;
      11: e_imm = 64'((w >> 11) & 32'd31) + 64'(((w >> 1) & 32'd1) * 32);
      12: e_imm = 64'((w >> 11) & 32'd31);
      default: ;
    endcase
    if (s >= 3 && s <= 12) e_oks = 3'b100;
    e_rec = (rs == 1) ? 1'b1 : (rs == 2) ? w[0] : 1'b0;
    e_ovf = ((w >> 10) & 32'd1) != 0;
    e_lnk = lk ? w[0] : 1'b0;
  endtask

  task automatic compare_all(input int s);
    string t;
    t = tag_for(s);
    chk(t, imm_o, e_imm);
    chk((s >= 3 && s <= 12) ? "R10" : t, 64'({imm_ok_o, rd2_ok_o, spr2_ok_o}), 64'(e_oks));
    chk(t, 64'(rd2_idx_o), 64'(e_rd2));
    chk(t, 64'(spr2_num_o), 64'(e_spr));
    chk("R11", 64'({rec_ok_o, rec_o}), 64'({1'b1, e_rec}));
    chk("R12", 64'({ovf_ok_o, ovf_o}), 64'({1'b1, e_ovf}));
    chk("R13", 64'(link_o), 64'(e_lnk));
  endtask

  task automatic apply(input logic [31:0] w, input int s, input int rs, input logic lk);
    @(negedge clk);
    insn = w; sel2 = 4'(s); rsel = 2'(rs); lken = lk;
    predict(w, s, rs, lk);
    @(negedge clk);
    compare_all(s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] corner [8];
    logic [31:0] seed;
    logic [31:0] w;
    corner = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_8000, 32'h0000_7FFF,
               32'h0200_0000, 32'h0000_0402, 32'h0000_0001, 32'h8000_F803};
    seed = 32'h1357_9BDF;
    rst = 1'b1; insn = 32'hFFFF_FFFF; sel2 = 4'd10; rsel = 2'd1; lken = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", imm_o, 64'd0);
    chk("R1", 64'({imm_ok_o, rd2_ok_o, spr2_ok_o, rec_ok_o, ovf_ok_o, link_o}), 64'd0);
    rst = 1'b0;

    // R2: one-cycle latency, old value held until the next rising edge
    apply(32'hFFFF_FFFF, 3, 0, 1'b0);
    @(negedge clk);
    insn = 32'h0000_8000; sel2 = 4'd4;
    #1;
    chk("R2", imm_o, 64'h0000_0000_0000_FFFF);
    @(negedge clk);
    chk("R2", imm_o, 64'hFFFF_FFFF_FFFF_8000);

    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 64; k++) begin
        if (k < 8) w = corner[k];
        else begin
          seed = seed ^ (seed << 13);
          seed = seed ^ (seed >> 17);
          seed = seed ^ (seed << 5);
          w = seed;
        end
        apply(w, s, k % 4, 1'((k / 4) % 2));
      end
    end

    // R1: reset in mid-run clears loaded outputs
    apply(32'h1234_5678, 10, 1, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", imm_o, 64'd0);
    chk("R1", 64'({imm_ok_o, rec_ok_o, ovf_ok_o, rec_o}), 64'd0);
    rst = 1'b0;
    apply(32'h0000_0401, 2, 2, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule